// File: doc/BRIEF.md
# Polling Receiver Control Sequencer

This block sequences a low-power radio receiver that spends most of its time asleep and wakes up periodically to listen. Each wake-up walks a fixed chain of phases: a sleep interval, a PLL settling interval, a signal-path settling interval, a bit-check window and finally reception. The three timed phases are measured by a single down-counter that advances on a `tick` strobe, which the surrounding logic pulses once per half period of the basic clock. That lets the 798.5-period PLL settling time be counted as a whole number of ticks (1597).

The bit-check discriminator, the analog front end and the PLL are outside the block and appear only as strobes. If the check passes, two status bits are raised and the receive phase begins. Received data is then steered to an internal buffer, or straight to the serial pin when the pass-through mode is selected. If the check fails, the controller goes back to sleep. A bit error that arrives after a good check but before a start bit raises a sticky interrupt and restarts from PLL settling, unless pass-through mode is active.

Top module: `rxpoll_seq`

## Requirements
- R1: After a synchronous reset `phase` reads 0 (sleep), and `rx_active`, `clk_on`, `rx_mode`, `to_buf`, `to_pin` and `irq` are all 0.
- R2: `phase` encodes sleep=0, PLL settling=1, signal-path settling=2, bit check=3, receive=4. Settling 2 is entered only from 1, bit check only from 2, and receive only from bit check.
- R3: Sleep lasts L ticks, where L = 2 * `sleep_cnt` * SLEEP_UNIT * (EXT_MULT if `sleep_ext` is 1, else 1). `sleep_cnt` and `sleep_ext` are read when sleep is entered. When L is 0, sleep lasts exactly one tick.
- R4: PLL settling lasts exactly 1597 ticks.
- R5: Signal-path settling lasts 1860, 1092, 708 or 516 ticks for `rate_sel` values 0, 1, 2 and 3.
- R6: `rate_sel` and `transp` are captured on the clock edge that leaves sleep. Later changes to them have no effect until the next sleep exit.
- R7: In sleep, `rx_active`, `pll_en`, `sig_en` and `chk_en` are all 0. In every other phase `rx_active` and `pll_en` are 1. `sig_en` is 1 in phases 2, 3 and 4. `chk_en` is 1 only in phase 3.
- R8: A `chk_pass` strobe in phase 3 moves to phase 4 and sets `clk_on` and `rx_mode` to 1. `chk_pass` wins over a simultaneous `chk_fail`.
- R9: A `chk_fail` strobe alone in phase 3 returns to phase 0, with `clk_on` and `rx_mode` at 0.
- R10: In phase 4, with the captured `transp` at 0 and no start bit seen since entering phase 4, a `bit_err` strobe sets `irq` and moves to phase 1.
- R11: In phase 4, `bit_err` leaves the phase and `irq` unchanged when the captured `transp` is 1, or after a `start_bit` strobe has been seen in the current receive phase.
- R12: In phase 4, `to_pin` is 1 and `to_buf` is 0 when the captured `transp` is 1, and the reverse when it is 0. Both are 0 outside phase 4.
- R13: `irq` stays 1 until an `irq_clr` strobe arrives. When a set and a clear occur in the same cycle, the set wins.
- R14: An `rx_end` strobe in phase 4 returns to phase 0 and clears `clk_on` and `rx_mode`. It takes priority over `bit_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Half-period strobe of the basic clock |
| sleep_cnt | input | SLEEP_W | Sleep length field |
| sleep_ext | input | 1 | Extended sleep multiplier select |
| rate_sel | input | 2 | Bit-rate range |
| transp | input | 1 | Pass-through (transparent) data mode |
| chk_pass | input | 1 | Bit check passed strobe |
| chk_fail | input | 1 | Bit check failed strobe |
| start_bit | input | 1 | Start bit detected strobe |
| bit_err | input | 1 | Bit error strobe |
| rx_end | input | 1 | End of reception strobe |
| irq_clr | input | 1 | Interrupt clear strobe |
| phase | output | 3 | Current phase code |
| rx_active | output | 1 | Receiver active indicator |
| pll_en | output | 1 | PLL enable |
| sig_en | output | 1 | Signal path enable |
| chk_en | output | 1 | Bit-check discriminator enable |
| clk_on | output | 1 | Data clock running status |
| rx_mode | output | 1 | Receive operating mode status |
| to_buf | output | 1 | Data routed to internal buffer |
| to_pin | output | 1 | Data routed to serial pin |
| irq | output | 1 | Sticky interrupt |

## Verification
The hardest situation to reach is a bit error in the receive phase while the settling length is still governed by a range captured several thousand ticks earlier. Reaching it requires completing a full sleep, PLL and signal-path walk under irregular ticks, and changing `rate_sel` and `transp` straight after the sleep exit. The bench drives each walk with randomly gapped ticks and counts only the ticks the design actually sees. It then injects the error and measures the restarted PLL and settling phases against the range captured originally. Directed cycles add a zero-length sleep, a maximum extended sleep, a set-and-clear collision on the interrupt, and simultaneous pass and fail strobes.

// File: rtl/rxpoll_pkg.sv
package rxpoll_pkg;

   typedef enum logic [2:0] {
      PH_SLEEP = 3'd0,
      PH_PLL   = 3'd1,
      PH_SIG   = 3'd2,
      PH_CHK   = 3'd3,
      PH_RX    = 3'd4
   } phase_t;

   // PLL settling, in half periods of the basic clock
   localparam int PLL_TICKS = 1597;
   localparam int SIG_MAX_TICKS = 1860;

   // Signal-path settling in half periods, per bit-rate range
   function automatic int sig_ticks(input logic [1:0] range);
      case (range)
         2'd0:    return 1860;
         2'd1:    return 1092;
         2'd2:    return 708;
         default: return 516;
      endcase
   endfunction

endpackage

// File: rtl/rxpoll_timer.sv
module rxpoll_timer #(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick,
   input  logic [CW-1:0] rst_val,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expire
);

   logic [CW-1:0] remain;

   // the tick that finds the count at zero ends the phase
   assign expire = tick && (remain == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         remain <= rst_val;
      end else if (load) begin
         remain <= load_val;
      end else if (tick && (remain != '0)) begin
         remain <= remain - CW'(1);
      end
   end

endmodule

// File: rtl/rxpoll_ctrl.sv
module rxpoll_ctrl
   import rxpoll_pkg::*;
#(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          expire,
   input  logic [CW-1:0] sleep_ld,
   input  logic [1:0]    rate_in,
   input  logic          transp_in,
   input  logic          chk_pass,
   input  logic          chk_fail,
   input  logic          start_bit,
   input  logic          bit_err,
   input  logic          rx_end,
   input  logic          irq_clr,
   output phase_t        state,
   output logic          load,
   output logic [CW-1:0] load_val,
   output logic          rx_on,
   output logic          transp_q,
   output logic          irq
);

   phase_t     nxt;
   logic [1:0] rate_q;
   logic       start_seen;
   logic       irq_set;
   logic       to_sleep;

   always_comb begin
      nxt      = state;
      load     = 1'b0;
      load_val = '0;
      irq_set  = 1'b0;
      to_sleep = 1'b0;
      unique case (state)
         PH_SLEEP: if (expire) begin
            nxt      = PH_PLL;
            load     = 1'b1;
            load_val = CW'(PLL_TICKS - 1);
         end
         PH_PLL: if (expire) begin
            nxt      = PH_SIG;
            load     = 1'b1;
            load_val = CW'(sig_ticks(rate_q) - 1);
         end
         PH_SIG: if (expire) begin
            nxt = PH_CHK;
         end
         PH_CHK: begin
            if (chk_pass) begin
               nxt = PH_RX;
            end else if (chk_fail) begin
               nxt      = PH_SLEEP;
               load     = 1'b1;
               load_val = sleep_ld;
               to_sleep = 1'b1;
            end
         end
         PH_RX: begin
            if (rx_end) begin
               nxt      = PH_SLEEP;
               load     = 1'b1;
               load_val = sleep_ld;
               to_sleep = 1'b1;
            end else if (bit_err && !transp_q && !start_seen) begin
               nxt      = PH_PLL;
               load     = 1'b1;
               load_val = CW'(PLL_TICKS - 1);
               irq_set  = 1'b1;
            end
         end
         default: nxt = PH_SLEEP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state      <= PH_SLEEP;
         rate_q     <= '0;
         transp_q   <= 1'b0;
         rx_on      <= 1'b0;
         start_seen <= 1'b0;
         irq        <= 1'b0;
      end else begin
         state <= nxt;
         if (state == PH_SLEEP && expire) begin
            rate_q   <= rate_in;
            transp_q <= transp_in;
         end
         if (state == PH_CHK && chk_pass) begin
            rx_on <= 1'b1;
         end else if (to_sleep) begin
            rx_on <= 1'b0;
         end
         if (state == PH_RX && nxt == PH_RX) begin
            if (start_bit) start_seen <= 1'b1;
         end else begin
            start_seen <= 1'b0;
         end
         if (irq_set) begin
            irq <= 1'b1;
         end else if (irq_clr) begin
            irq <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/rxpoll_seq.sv
module rxpoll_seq
   import rxpoll_pkg::*;
#(
   parameter int SLEEP_W    = 5,
   parameter int SLEEP_UNIT = 1024,
   parameter int EXT_MULT   = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               tick,
   input  logic [SLEEP_W-1:0] sleep_cnt,
   input  logic               sleep_ext,
   input  logic [1:0]         rate_sel,
   input  logic               transp,
   input  logic               chk_pass,
   input  logic               chk_fail,
   input  logic               start_bit,
   input  logic               bit_err,
   input  logic               rx_end,
   input  logic               irq_clr,
   output logic [2:0]         phase,
   output logic               rx_active,
   output logic               pll_en,
   output logic               sig_en,
   output logic               chk_en,
   output logic               clk_on,
   output logic               rx_mode,
   output logic               to_buf,
   output logic               to_pin,
   output logic               irq
);

   localparam int SLEEP_MAX = 2 * (2**SLEEP_W - 1) * SLEEP_UNIT * EXT_MULT;
   localparam int LEN_MAX   = (SLEEP_MAX > SIG_MAX_TICKS) ? SLEEP_MAX : SIG_MAX_TICKS;
   localparam int CW        = $clog2(LEN_MAX + 1);
   localparam logic [CW-1:0] UNIT2 = CW'(2 * SLEEP_UNIT);

   if (SLEEP_W < 1 || SLEEP_W > 16) begin : g_bad_w
      $error("rxpoll_seq: SLEEP_W must lie in 1..16");
   end
   if (SLEEP_UNIT < 1) begin : g_bad_unit
      $error("rxpoll_seq: SLEEP_UNIT must be at least 1");
   end
   if (EXT_MULT < 1) begin : g_bad_mult
      $error("rxpoll_seq: EXT_MULT must be at least 1");
   end

   logic [CW-1:0] base_len;
   logic [CW-1:0] sleep_len;
   logic [CW-1:0] sleep_ld;

   assign base_len = CW'(sleep_cnt) * UNIT2;

   if (EXT_MULT == 1) begin : g_no_ext
      assign sleep_len = base_len;
   end else begin : g_ext
      localparam logic [CW-1:0] MULT = CW'(EXT_MULT);
      assign sleep_len = sleep_ext ? base_len * MULT : base_len;
   end

   // a zero length still costs one tick
   assign sleep_ld = (sleep_len == '0) ? '0 : sleep_len - CW'(1);

   logic          expire;
   logic          load;
   logic [CW-1:0] load_val;
   phase_t        state;
   logic          rx_on;
   logic          transp_q;

   rxpoll_timer #(.CW(CW)) i_timer (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .rst_val  (sleep_ld),
      .load     (load),
      .load_val (load_val),
      .expire   (expire)
   );

   rxpoll_ctrl #(.CW(CW)) i_ctrl (
      .clk       (clk),
      .rst       (rst),
      .expire    (expire),
      .sleep_ld  (sleep_ld),
      .rate_in   (rate_sel),
      .transp_in (transp),
      .chk_pass  (chk_pass),
      .chk_fail  (chk_fail),
      .start_bit (start_bit),
      .bit_err   (bit_err),
      .rx_end    (rx_end),
      .irq_clr   (irq_clr),
      .state     (state),
      .load      (load),
      .load_val  (load_val),
      .rx_on     (rx_on),
      .transp_q  (transp_q),
      .irq       (irq)
   );

   assign phase     = state;
   assign rx_active = (state != PH_SLEEP);
   assign pll_en    = (state != PH_SLEEP);
   assign sig_en    = (state == PH_SIG) || (state == PH_CHK) || (state == PH_RX);
   assign chk_en    = (state == PH_CHK);
   assign clk_on    = rx_on;
   assign rx_mode   = rx_on;
   assign to_pin    = (state == PH_RX) && transp_q;
   assign to_buf    = (state == PH_RX) && !transp_q;

endmodule

// File: rtl/rxpoll_seq_chk.sv
module rxpoll_seq_chk (
   input logic       clk,
   input logic       rst,
   input logic       chk_pass,
   input logic       chk_fail,
   input logic       bit_err,
   input logic       rx_end,
   input logic       irq_clr,
   input logic [2:0] phase,
   input logic       rx_active,
   input logic       pll_en,
   input logic       sig_en,
   input logic       chk_en,
   input logic       clk_on,
   input logic       rx_mode,
   input logic       to_buf,
   input logic       to_pin,
   input logic       irq
);

   assert_sleep_idle_R7: assert property (@(posedge clk) disable iff (rst)
      (phase == 3'd0) |-> (!rx_active && !pll_en && !sig_en && !chk_en));

   assert_order_sig_R2: assert property (@(posedge clk) disable iff (rst)
      (phase == 3'd2 && $past(phase) != 3'd2) |-> ($past(phase) == 3'd1));

   assert_order_chk_R2: assert property (@(posedge clk) disable iff (rst)
      (phase == 3'd3 && $past(phase) != 3'd3) |-> ($past(phase) == 3'd2));

   assert_order_rx_R2: assert property (@(posedge clk) disable iff (rst)
      (phase == 3'd4 && $past(phase) != 3'd4) |-> ($past(phase) == 3'd3));

   assert_pass_R8: assert property (@(posedge clk) disable iff (rst)
      (phase == 3'd3 && chk_pass) |=> (phase == 3'd4 && clk_on && rx_mode));

   assert_fail_R9: assert property (@(posedge clk) disable iff (rst)
      (phase == 3'd3 && chk_fail && !chk_pass) |=> (phase == 3'd0 && !clk_on));

   assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
      $rose(irq) |-> ($past(phase) == 3'd4 && $past(bit_err)));

   assert_irq_hold_R13: assert property (@(posedge clk) disable iff (rst)
      (irq && !irq_clr) |=> irq);

   assert_route_excl_R12: assert property (@(posedge clk) disable iff (rst)
      $onehot0({to_buf, to_pin}));

   assert_route_idle_R12: assert property (@(posedge clk) disable iff (rst)
      (phase != 3'd4) |-> (!to_buf && !to_pin));

   assert_end_R14: assert property (@(posedge clk) disable iff (rst)
      (phase == 3'd4 && rx_end) |=> (phase == 3'd0 && !rx_mode));

endmodule

bind rxpoll_seq rxpoll_seq_chk i_chk (
   .clk       (clk),
   .rst       (rst),
   .chk_pass  (chk_pass),
   .chk_fail  (chk_fail),
   .bit_err   (bit_err),
   .rx_end    (rx_end),
   .irq_clr   (irq_clr),
   .phase     (phase),
   .rx_active (rx_active),
   .pll_en    (pll_en),
   .sig_en    (sig_en),
   .chk_en    (chk_en),
   .clk_on    (clk_on),
   .rx_mode   (rx_mode),
   .to_buf    (to_buf),
   .to_pin    (to_pin),
   .irq       (irq)
);

// File: tb/test_rxpoll_seq.sv
`timescale 1ns/1ps
module test_rxpoll_seq;

   localparam int SW    = 5;
   localparam int UNIT  = 2;
   localparam int MULT  = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          tick = 1'b0;
   logic [SW-1:0] sleep_cnt = '0;
   logic          sleep_ext = 1'b0;
   logic [1:0]    rate_sel = '0;
   logic          transp = 1'b0;
   logic          chk_pass = 1'b0, chk_fail = 1'b0, start_bit = 1'b0;
   logic          bit_err = 1'b0, rx_end = 1'b0, irq_clr = 1'b0;
   logic [2:0]    phase;
   logic          rx_active, pll_en, sig_en, chk_en, clk_on, rx_mode;
   logic          to_buf, to_pin, irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit gappy = 1'b0;
   bit done  = 1'b0;
   int exp_sleep_len;

   always #2.5 clk = ~clk;

   rxpoll_seq #(.SLEEP_W(SW), .SLEEP_UNIT(UNIT), .EXT_MULT(MULT)) i_rxpoll_seq (
      .clk(clk), .rst(rst), .tick(tick), .sleep_cnt(sleep_cnt), .sleep_ext(sleep_ext),
      .rate_sel(rate_sel), .transp(transp), .chk_pass(chk_pass), .chk_fail(chk_fail),
      .start_bit(start_bit), .bit_err(bit_err), .rx_end(rx_end), .irq_clr(irq_clr),
      .phase(phase), .rx_active(rx_active), .pll_en(pll_en), .sig_en(sig_en),
      .chk_en(chk_en), .clk_on(clk_on), .rx_mode(rx_mode), .to_buf(to_buf),
      .to_pin(to_pin), .irq(irq)
   );

   function automatic int sleep_ticks(input int s, input bit ext);
      int l = 2 * s * UNIT * (ext ? MULT : 1);
      return (l == 0) ? 1 : l;
   endfunction

   function automatic int sig_len(input int r);
      case (r)
         0: return 1860;
         1: return 1092;
         2: return 708;
         default: return 516;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic measure(input int ph, output int n);
      n = 0;
      while (phase == 3'(ph)) begin
         tick = gappy ? (($urandom % 4) != 0) : 1'b1;
         @(posedge clk);
         if (tick) n++;
         @(negedge clk);
      end
      tick = 1'b0;
   endtask

   task automatic strobe(input int which, input bit also_other);
      @(negedge clk);
      case (which)
         0: begin chk_pass = 1'b1; chk_fail = also_other; end
         1: chk_fail = 1'b1;
         2: start_bit = 1'b1;
         3: begin bit_err = 1'b1; irq_clr = also_other; end
         4: begin rx_end = 1'b1; bit_err = also_other; end
         default: irq_clr = 1'b1;
      endcase
      @(negedge clk);
      chk_pass = 1'b0; chk_fail = 1'b0; start_bit = 1'b0;
      bit_err = 1'b0; rx_end = 1'b0; irq_clr = 1'b0;
   endtask

   task automatic set_sleep(input int s, input bit e);
      sleep_cnt = SW'(s);
      sleep_ext = e;
      exp_sleep_len = sleep_ticks(s, e);
   endtask

   // settling walk from PLL to bit check with the captured range
   task automatic walk_settle(input int r);
      int n;
      check(rx_active && pll_en && !sig_en && phase == 3'd1, "R7", int'(phase), 1);
      measure(1, n);
      check(n == 1597, "R4", n, 1597);
      check(phase == 3'd2 && sig_en && !chk_en, "R2", int'(phase), 2);
      measure(2, n);
      check(n == sig_len(r), "R5/R6", n, sig_len(r));
      check(phase == 3'd3 && chk_en && sig_en, "R7", int'(phase), 3);
   endtask

   // kind: 0 fail, 1 error restart, 2 error with clear collision, 3 start then error, 4 transparent error
   task automatic cycle(input int r, input bit tr, input int kind, input int ns, input bit ne);
      int n;
      bit tr_eff;
      rate_sel = 2'(r);
      transp = (kind == 4) ? 1'b1 : ((kind == 3) ? tr : 1'b0);
      tr_eff = transp;
      measure(0, n);
      check(n == exp_sleep_len, "R3", n, exp_sleep_len);
      rate_sel = ~rate_sel;
      transp = ~transp;
      walk_settle(r);
      if (kind == 0) begin
         set_sleep(ns, ne);
         strobe(1, 1'b0);
         check(phase == 3'd0 && !clk_on && !rx_mode && !rx_active, "R9", int'(phase), 0);
         return;
      end
      strobe(0, (kind == 2));
      check(phase == 3'd4 && clk_on && rx_mode, "R8", int'(phase), 4);
      check(to_pin == tr_eff && to_buf == !tr_eff, "R12", int'(to_pin), int'(tr_eff));
      if (kind == 1 || kind == 2) begin
         strobe(3, (kind == 2));
         check(phase == 3'd1 && irq, "R10", int'(phase), 1);
         check(irq == 1'b1, "R13", int'(irq), 1);
         check(!to_buf && !to_pin, "R12", int'(to_buf), 0);
         strobe(5, 1'b0);
         check(irq == 1'b0, "R13", int'(irq), 0);
         walk_settle(r);
         set_sleep(ns, ne);
         strobe(1, 1'b0);
         check(phase == 3'd0 && !clk_on, "R9", int'(phase), 0);
      end else begin
         if (kind == 3 && !tr_eff) strobe(2, 1'b0);
         strobe(3, 1'b0);
         check(phase == 3'd4 && !irq, "R11", int'(phase), 4);
         set_sleep(ns, ne);
         strobe(4, 1'b1);
         check(phase == 3'd0 && !clk_on && !rx_mode && !irq, "R14", int'(phase), 0);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      set_sleep(3, 1'b0);
      repeat (4) @(negedge clk);
      check(phase == 3'd0 && !rx_active && !clk_on && !rx_mode && !irq && !to_buf && !to_pin,
            "R1", int'(phase), 0);
      rst = 1'b0;
      @(negedge clk);
      check(phase == 3'd0 && !rx_active && !irq, "R1", int'(rx_active), 0);
      // directed corners
      cycle(0, 1'b0, 0, 0, 1'b0);
      cycle(1, 1'b0, 1, 31, 1'b1);
      cycle(2, 1'b0, 2, 5, 1'b1);
      cycle(3, 1'b1, 4, 1, 1'b0);
      cycle(0, 1'b0, 3, 2, 1'b0);
      // random cycles with gapped ticks
      gappy = 1'b1;
      for (int i = 0; i < 7; i++) begin
         cycle(int'($urandom % 4), 1'($urandom % 2), int'($urandom % 5),
               int'($urandom % 32), 1'($urandom % 2));
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule